// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This unit sits between the execute stage of a 32-bit integer core and a word-organised data memory. For every memory operation it forms the byte address by adding a sign-extended 12-bit displacement to a base register value, decodes the operation's width and signedness from the 3-bit width code, and turns the request into a word address, a per-byte write mask and steered write data. On the way back it picks the addressed byte or half-word out of the returned memory word and widens it to 32 bits with either copies of its top bit or zeros.

Accesses that are not naturally aligned, and width codes that name no access, are flagged in the request cycle and never reach the memory: no byte is written and no read is issued. The memory is expected to answer a read one cycle after the request; the widened result is registered one cycle after that, alongside a valid pulse. Byte order is little-endian throughout.

Top module: `lsu_lane_align`

## Requirements
- R1: The byte address is base plus the displacement sign-extended from its bit 11; `mem_addr` presents that byte address with its two low bits removed, in the same cycle as the request.
- R2: Width codes decode as 000 signed byte, 001 signed half, 010 word, 100 unsigned byte, 101 unsigned half; any of 011, 110 or 111 on a valid request raises `bad_width` and issues neither a read nor a write.
- R3: On a store, `mem_wdata` carries the low byte of the source replicated in all four lanes, or the low half replicated in both halves, or the full word; upper source bits beyond the access width never appear.
- R4: An aligned store sets strobe bit k for byte k of the word: a single bit at lane addr[1:0] for a byte, 0011 or 1100 for a half at lane 0 or 2, 1111 for a word; with no store, the strobes are 0000.
- R5: `misalign` rises for a half access at an odd address and for a word access whose address is not a multiple of four; byte accesses and aligned accesses never raise it.
- R6: A misaligned or badly coded request drives all strobes to zero and keeps `mem_re` low; an aligned valid load drives `mem_re` high in its request cycle.
- R7: A byte load returns the addressed byte in bits 7:0 with bits 31:8 copied from its bit 7 when signed (000) and zero when unsigned (100).
- R8: A half load returns the addressed half in bits 15:0 with bits 31:16 copied from its bit 15 when signed (001) and zero when unsigned (101).
- R9: A word load returns the memory word unchanged.
- R10: `ld_valid` pulses in the cycle after `mem_rvalid`, with `ld_data` updated on that same edge and held otherwise; back-to-back loads each produce their own result.
- R11: While reset is asserted and after its release until the first result, `ld_valid` and `ld_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A memory operation is presented this cycle |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_width | input | 3 | Width and signedness code |
| req_base | input | 32 | Base register value |
| req_disp | input | 12 | Signed displacement |
| req_src | input | 32 | Store source register value |
| mem_addr | output | 30 | Word address to memory |
| mem_wstrb | output | 4 | Per-byte write enables |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_re | output | 1 | Read request to memory |
| mem_rvalid | input | 1 | Read data returned this cycle |
| mem_rdata | input | 32 | Returned memory word |
| misalign | output | 1 | Request not naturally aligned |
| bad_width | output | 1 | Request width code names no access |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Widened load result |

## Verification
The assertions rely on the memory returning `mem_rvalid` exactly one cycle after each `mem_re` and on at most one request per cycle, since the unit keeps one load context and overwrites it on every issued read. The bench's memory model answers with that fixed latency, drives one request per clock, and mixes idle cycles, back-to-back loads, negative and positive displacements, every width code and every lane so that both flags and all widening paths are reached under that contract.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  localparam int WORD_BYTES = 4;
  localparam int WORD_BITS  = 8 * WORD_BYTES;
  localparam int LANE_W     = $clog2(WORD_BYTES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    acc_size_e size;
    logic      unsgn;
    logic      legal;
  } acc_kind_t;

  function automatic acc_kind_t decode_kind(input logic [2:0] code);
    acc_kind_t k;
    k.unsgn = code[2];
    k.legal = 1'b1;
    unique case (code)
      3'b000, 3'b100: k.size = SZ_BYTE;
      3'b001, 3'b101: k.size = SZ_HALF;
      3'b010:         k.size = SZ_WORD;
      default: begin
        k.size  = SZ_BYTE;
        k.legal = 1'b0;
      end
    endcase
    return k;
  endfunction

  function automatic logic is_misaligned(input acc_size_e sz, input logic [LANE_W-1:0] low);
    unique case (sz)
      SZ_HALF: return low[0];
      SZ_WORD: return |low;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [WORD_BYTES-1:0] lane_mask(input acc_size_e sz,
                                                      input logic [LANE_W-1:0] lane);
    logic [WORD_BYTES-1:0] base;
    unique case (sz)
      SZ_HALF: base = WORD_BYTES'(2'b11);
      SZ_WORD: base = '1;
      default: base = WORD_BYTES'(1'b1);
    endcase
    return base << lane;
  endfunction

  function automatic logic [WORD_BITS-1:0] widen(input logic [WORD_BITS-1:0] word,
                                                 input acc_kind_t k,
                                                 input logic [LANE_W-1:0] lane);
    logic [WORD_BITS-1:0] sh;
    logic                 fill;
    sh = word >> {lane, 3'b000};
    unique case (k.size)
      SZ_BYTE: begin
        fill = ~k.unsgn & sh[7];
        return {{(WORD_BITS-8){fill}}, sh[7:0]};
      end
      SZ_HALF: begin
        fill = ~k.unsgn & sh[15];
        return {{(WORD_BITS-16){fill}}, sh[15:0]};
      end
      default: return word;
    endcase
  endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [2:0]        req_width,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [DISP_W-1:0] req_disp,
  output logic [ADDR_W-1:0] eff_addr,
  output acc_kind_t         kind,
  output logic              misalign,
  output logic              bad_width,
  output logic              go_load,
  output logic              go_store
);

  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;
  logic              fault;

  always_comb begin
    disp_ext  = {{EXT_W{req_disp[DISP_W-1]}}, req_disp};
    eff_addr  = req_base + disp_ext;
    kind      = decode_kind(req_width);
    bad_width = req_valid & ~kind.legal;
    misalign  = req_valid & kind.legal & is_misaligned(kind.size, eff_addr[LANE_W-1:0]);
    fault     = bad_width | misalign;
    go_store  = req_valid & req_store & ~fault;
    go_load   = req_valid & ~req_store & ~fault;
  end

  assert_byte_never_misaligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_width == 3'b000 || req_width == 3'b100)) |-> !misalign);

  assert_bad_code_blocks_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bad_width |-> (!go_load && !go_store && !misalign));

endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go_store,
  input  acc_size_e             size,
  input  logic [LANE_W-1:0]     lane,
  input  logic [WORD_BITS-1:0]  src,
  output logic [WORD_BYTES-1:0] wstrb,
  output logic [WORD_BITS-1:0]  wdata
);

  logic [WORD_BYTES-1:0] mask;

  assign mask  = lane_mask(size, lane);
  assign wstrb = go_store ? mask : '0;

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
    always_comb begin
      unique case (size)
        SZ_BYTE: wdata[8*k +: 8] = src[7:0];
        SZ_HALF: wdata[8*k +: 8] = src[8*(k % 2) +: 8];
        default: wdata[8*k +: 8] = src[8*k +: 8];
      endcase
    end
  end

  assert_strobe_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wstrb != '0) |-> ($countones(wstrb) == 1 || $countones(wstrb) == 2 ||
                       $countones(wstrb) == WORD_BYTES));

  assert_strobe_needs_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !go_store |-> (wstrb == '0));

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue,
  input  acc_kind_t            issue_kind,
  input  logic [LANE_W-1:0]    issue_lane,
  input  logic                 mem_rvalid,
  input  logic [WORD_BITS-1:0] mem_rdata,
  output logic                 ld_valid,
  output logic [WORD_BITS-1:0] ld_data
);

  acc_kind_t            ctx_kind;
  logic [LANE_W-1:0]    ctx_lane;
  acc_kind_t            out_kind;
  logic [WORD_BITS-1:0] widened;

  assign widened = widen(mem_rdata, ctx_kind, ctx_lane);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctx_kind <= '0;
      ctx_lane <= '0;
    end else if (issue) begin
      ctx_kind <= issue_kind;
      ctx_lane <= issue_lane;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_valid <= 1'b0;
      ld_data  <= '0;
      out_kind <= '0;
    end else begin
      ld_valid <= mem_rvalid;
      if (mem_rvalid) begin
        ld_data  <= widened;
        out_kind <= ctx_kind;
      end
    end
  end

  assert_result_follows_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(mem_rvalid));

  assert_data_held_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_valid && !$past(!rst_n)) |-> $stable(ld_data));

  assert_unsigned_byte_zero_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && out_kind.unsgn && out_kind.size == SZ_BYTE) |-> (ld_data[WORD_BITS-1:8] == '0));

  assert_unsigned_half_zero_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && out_kind.unsgn && out_kind.size == SZ_HALF) |-> (ld_data[WORD_BITS-1:16] == '0));

endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_store,
  input  logic [2:0]            req_width,
  input  logic [ADDR_W-1:0]     req_base,
  input  logic [DISP_W-1:0]     req_disp,
  input  logic [WORD_BITS-1:0]  req_src,
  output logic [ADDR_W-3:0]     mem_addr,
  output logic [WORD_BYTES-1:0] mem_wstrb,
  output logic [WORD_BITS-1:0]  mem_wdata,
  output logic                  mem_re,
  input  logic                  mem_rvalid,
  input  logic [WORD_BITS-1:0]  mem_rdata,
  output logic                  misalign,
  output logic                  bad_width,
  output logic                  ld_valid,
  output logic [WORD_BITS-1:0]  ld_data
);

  logic [ADDR_W-1:0] eff_addr;
  acc_kind_t         kind;
  logic              go_load;
  logic              go_store;

  lsu_addr_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_store (req_store),
    .req_width (req_width),
    .req_base  (req_base),
    .req_disp  (req_disp),
    .eff_addr  (eff_addr),
    .kind      (kind),
    .misalign  (misalign),
    .bad_width (bad_width),
    .go_load   (go_load),
    .go_store  (go_store)
  );

  lsu_store_steer u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_store (go_store),
    .size     (kind.size),
    .lane     (eff_addr[LANE_W-1:0]),
    .src      (req_src),
    .wstrb    (mem_wstrb),
    .wdata    (mem_wdata)
  );

  lsu_load_extract u_load (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (go_load),
    .issue_kind (kind),
    .issue_lane (eff_addr[LANE_W-1:0]),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .ld_valid   (ld_valid),
    .ld_data    (ld_data)
  );

  assign mem_addr = eff_addr[ADDR_W-1:LANE_W];
  assign mem_re   = go_load;

  assert_fault_blocks_memory_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (misalign || bad_width) |-> (mem_wstrb == '0 && !mem_re));

  assert_no_read_and_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (mem_wstrb == '0));

endmodule

// File: tb/sim_lsu_lane_align.sv
module sim_lsu_lane_align;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_store = 1'b0;
  logic [2:0]  req_width = 3'b000;
  logic [31:0] req_base = '0;
  logic [11:0] req_disp = '0;
  logic [31:0] req_src = '0;
  logic [29:0] mem_addr;
  logic [3:0]  mem_wstrb;
  logic [31:0] mem_wdata;
  logic        mem_re;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        misalign;
  logic        bad_width;
  logic        ld_valid;
  logic [31:0] ld_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] mem     [16];
  logic [31:0] ref_mem [16];

  // expected-result pipeline: stage 0 = issued last cycle, stage 1 = due now
  bit          pv0 = 0, pv1 = 0;
  logic [31:0] pd0 = '0, pd1 = '0;
  string       pt0 = "R9", pt1 = "R9";

  always #2 clk = ~clk;

  lsu_lane_align u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_width(req_width), .req_base(req_base), .req_disp(req_disp), .req_src(req_src),
    .mem_addr(mem_addr), .mem_wstrb(mem_wstrb), .mem_wdata(mem_wdata), .mem_re(mem_re),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .misalign(misalign),
    .bad_width(bad_width), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // memory model with one-cycle read latency
  always @(posedge clk) begin
    for (int i = 0; i < 4; i++)
      if (mem_wstrb[i]) mem[mem_addr[3:0]][8*i +: 8] <= mem_wdata[8*i +: 8];
    mem_rvalid <= mem_re;
    if (mem_re) mem_rdata <= mem[mem_addr[3:0]];
  end

  // reference model, compared on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int unsigned ea, bytes, lane, word, val;
      bit          illegal, mis, ld_ok, st_ok, uns;
      logic [3:0]  exp_strb;
      logic [31:0] exp_wd;

      ea      = req_base + 32'($signed(req_disp));
      illegal = (req_width[1:0] == 2'd3) || (req_width[2] && req_width[1]);
      bytes   = 1 << req_width[1:0];
      uns     = req_width[2];
      lane    = ea % 4;
      mis     = !illegal && (ea % bytes != 0);
      st_ok   = req_valid && req_store && !illegal && !mis;
      ld_ok   = req_valid && !req_store && !illegal && !mis;
      exp_strb = st_ok ? 4'(((1 << bytes) - 1) << lane) : 4'b0000;
      if (bytes == 1)      exp_wd = {4{req_src[7:0]}};
      else if (bytes == 2) exp_wd = {2{req_src[15:0]}};
      else                 exp_wd = req_src;

      check("R1 mem_addr", {2'b00, mem_addr}, ea >> 2);
      check("R2 bad_width", {31'b0, bad_width}, {31'b0, req_valid && illegal});
      check("R5 misalign", {31'b0, misalign}, {31'b0, req_valid && mis});
      check("R4 wstrb", {28'b0, mem_wstrb}, {28'b0, exp_strb});
      check("R6 mem_re", {31'b0, mem_re}, {31'b0, ld_ok});
      if (st_ok) check("R3 wdata", mem_wdata, exp_wd);

      // results due now
      check("R10 ld_valid", {31'b0, ld_valid}, {31'b0, pv1});
      if (pv1) check(pt1, ld_data, pd1);

      pv1 = pv0; pd1 = pd0; pt1 = pt0;
      pv0 = ld_ok;
      if (ld_ok) begin
        word = ref_mem[(ea >> 2) % 16];
        val  = word >> (8 * lane);
        if (bytes == 1) begin
          val = val & 32'hFF;
          if (!uns && val[7]) val = val | 32'hFFFF_FF00;
          pt0 = "R7 byte load";
        end else if (bytes == 2) begin
          val = val & 32'hFFFF;
          if (!uns && val[15]) val = val | 32'hFFFF_0000;
          pt0 = "R8 half load";
        end else begin
          val = word;
          pt0 = "R9 word load";
        end
        pd0 = val;
      end
      if (st_ok)
        for (int i = 0; i < 4; i++)
          if (exp_strb[i]) ref_mem[(ea >> 2) % 16][8*i +: 8] = exp_wd[8*i +: 8];
    end
  end

  task automatic issue(input bit st, input logic [2:0] w, input logic [31:0] b,
                       input logic [11:0] d, input logic [31:0] s);
    @(posedge clk); #1;
    req_valid = 1'b1; req_store = st; req_width = w;
    req_base = b; req_disp = d; req_src = s;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    req_valid = 1'b0; req_store = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i]     = 32'h7F80_01FE ^ (i * 32'h0901_8311);
      ref_mem[i] = 32'h7F80_01FE ^ (i * 32'h0901_8311);
    end
    repeat (3) @(posedge clk);
    #1;
    // R11: reset values
    check("R11 ld_valid in reset", {31'b0, ld_valid}, 32'h0);
    check("R11 ld_data in reset", ld_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 ld_data after reset", ld_data, 32'h0);

    // initial content reads of every kind and lane (R7, R8, R9)
    for (int w = 0; w < 8; w++)
      for (int ln = 0; ln < 4; ln++)
        issue(1'b0, 3'(w), 32'h0000_0140 + 32'(ln), 12'h000, 32'h0);
    idle();

    // stores then loads, negative displacement, all codes and lanes (R1-R10)
    for (int w = 0; w < 8; w++)
      for (int ln = 0; ln < 4; ln++) begin
        logic [31:0] src;
        src = 32'h9E8D_F0B7 + 32'(w) * 32'h0403_0201 + 32'(ln) * 32'h1111_1111;
        issue(1'b1, 3'(w), 32'h0000_0108 + 32'(ln) + 32'(w * 4), 12'hFF8, src);
        issue(1'b0, 3'(w), 32'h0000_0100 + 32'(ln) + 32'(w * 4), 12'h000, 32'h0);
        if (ln == 1) idle();
      end
    idle();

    // positive displacement wrap into a different word, back-to-back word loads
    issue(1'b1, 3'b010, 32'h0000_0130, 12'h00C, 32'h0123_4567);
    issue(1'b1, 3'b000, 32'h0000_0130, 12'h00D, 32'hFFFF_FF80);
    issue(1'b1, 3'b001, 32'h0000_0130, 12'h00E, 32'hABCD_7FFE);
    issue(1'b0, 3'b010, 32'h0000_013C, 12'h000, 32'h0);
    issue(1'b0, 3'b000, 32'h0000_013C, 12'h001, 32'h0);
    issue(1'b0, 3'b100, 32'h0000_013C, 12'h001, 32'h0);
    issue(1'b0, 3'b001, 32'h0000_013C, 12'h002, 32'h0);
    issue(1'b0, 3'b101, 32'h0000_013C, 12'h002, 32'h0);
    // misaligned stores must leave memory untouched (R6), then read back
    issue(1'b1, 3'b010, 32'h0000_013D, 12'h000, 32'hDEAD_BEEF);
    issue(1'b1, 3'b001, 32'h0000_013F, 12'h000, 32'hDEAD_BEEF);
    issue(1'b1, 3'b011, 32'h0000_013C, 12'h000, 32'hDEAD_BEEF);
    issue(1'b0, 3'b010, 32'h0000_013C, 12'h000, 32'h0);
    idle();
    repeat (4) idle();
    done = 1;
    finish_run();
  end

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

endmodule